// File: doc/BRIEF.md
# Banked RAM Window Mapper

This block sits between a CPU with a 16-bit address bus and a physical RAM of up to 512K organised as 16K blocks. The CPU address space is divided into four 16K windows. A banking command, written over the same 8-bit data path used by the other video/memory control functions, chooses one of eight fixed window layouts together with a 64K expansion bank. For every CPU access the block produces the physical RAM address, made of a 5-bit physical block number above the 14-bit offset, plus separate RAM read, RAM write and ROM-select strobes.

A lower ROM can overlay the lowest 16K window. The overlay applies to reads only: writes into that range always reach the RAM underneath. The video fetch path gets its own physical address, which always lies in the base 64K whatever the banking command says. Logical blocks 0 to 3 always come from the base 64K. Logical blocks 4 to 7 come from the selected expansion bank. When the bank number exceeds the installed bank count, it wraps modulo that count.

Top module: `bank_window_map`

## Requirements
- R1: After reset the command register holds layout 0 and bank 0, so `ram_addr` equals `{3'b000, cpu_addr}`.
- R2: A write strobe whose `cfg_data[7:6]` is `2'b11` loads the bank from `cfg_data[5:3]` and the layout from `cfg_data[2:0]`. The new mapping appears on `ram_addr` in the cycle after the capturing clock edge.
- R3: A write strobe with any other value in `cfg_data[7:6]` leaves the mapping unchanged.
- R4: Layouts 0 to 3 give these logical blocks for windows 0,1,2,3 (window = `cpu_addr[15:14]`): layout 0 gives 0,1,2,3; layout 1 gives 0,1,2,7; layout 2 gives 4,5,6,7; layout 3 gives 0,3,2,7.
- R5: Layouts 4, 5, 6 and 7 give blocks 0,n,2,3, where n is 4, 5, 6 and 7 respectively.
- R6: The physical address is `{3'b000, blk[1:0], cpu_addr[13:0]}` for logical blocks 0 to 3, and `{bank, blk[1:0], cpu_addr[13:0]}` for logical blocks 4 to 7.
- R7: The bank used in R6 is the command's bank modulo parameter `BANK_COUNT`.
- R8: `vid_ram_addr` equals `{3'b000, vid_addr}` whatever the command register holds.
- R9: With `rom_lo_en` high, a read (`cpu_rd`) in 0000h to 3FFFh raises `rom_sel` and keeps `ram_rd` low. Reads anywhere else raise `ram_rd` and keep `rom_sel` low.
- R10: A write (`cpu_wr`) raises `ram_wr` and never `rom_sel`. This holds inside the ROM range with `rom_lo_en` high, and the write goes to the mapped RAM address.
- R11: With `rom_lo_en` low, a read in 0000h to 3FFFh raises `ram_rd` and keeps `rom_sel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control-port write strobe |
| cfg_data | input | 8 | Control-port write data |
| rom_lo_en | input | 1 | Lower ROM overlay enable |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| vid_addr | input | 16 | Video fetch address |
| ram_addr | output | 19 | Physical RAM address for the CPU access |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| rom_sel | output | 1 | Lower ROM selected for this read |
| vid_ram_addr | output | 19 | Physical RAM address for the video fetch |

## Verification
The case that is hardest to reach from the ports is the bank wrap. Every layout has to be combined with every bank number, and the wrap is only visible in windows that resolve to blocks 4 to 7 on a part with fewer banks than the command field can name. The bench reaches it by writing all 64 tagged commands and sweeping the four windows after each one. It drives a second instance, built with three banks, in parallel, so that banks 3 to 7 fold back. Random traffic mixes untagged writes, ROM-range writes with the overlay on, and video addresses with this sweep.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;

    localparam int CMD_W   = 8;
    localparam int BANK_W  = 3;
    localparam int LBLK_W  = 3;
    localparam int WIN_CNT = 4;
    localparam int WSEL_W  = 2;

    localparam logic [1:0] CMD_TAG = 2'b11;

    typedef enum logic [2:0] {
        LAY_FLAT    = 3'd0,
        LAY_TOP_X7  = 3'd1,
        LAY_ALL_EXP = 3'd2,
        LAY_SPLIT   = 3'd3,
        LAY_MID_X4  = 3'd4,
        LAY_MID_X5  = 3'd5,
        LAY_MID_X6  = 3'd6,
        LAY_MID_X7  = 3'd7
    } layout_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        layout_e           layout;
    } bank_cmd_t;

endpackage

// File: rtl/bank_cmd_reg.sv
module bank_cmd_reg
    import bankmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output bank_cmd_t        cmd_q
);

    logic hit;
    assign hit = wr_en && (wr_data[CMD_W-1 -: 2] == CMD_TAG);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '{bank: '0, layout: LAY_FLAT};
        end else if (hit) begin
            cmd_q <= '{bank: wr_data[BANK_W+2:3], layout: layout_e'(wr_data[2:0])};
        end
    end

    // R2: a tagged write lands in the register on the next edge
    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:6] == 2'b11) |=>
            (cmd_q.bank == $past(wr_data[5:3]) && cmd_q.layout == $past(wr_data[2:0])));

    // R3: anything but a tagged write keeps the register as it was
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[7:6] == 2'b11) |=> $stable(cmd_q));

endmodule

// File: rtl/win_layout.sv
module win_layout
    import bankmap_pkg::*;
(
    input  layout_e                         layout,
    output logic [WIN_CNT-1:0][LBLK_W-1:0]  win_blk
);

    function automatic logic [LBLK_W-1:0] pick(input layout_e lay, input logic [WSEL_W-1:0] w);
        logic [LBLK_W-1:0] b;
        unique case (lay)
            LAY_FLAT:    b = {1'b0, w};
            LAY_TOP_X7:  b = (w == 2'd3) ? 3'd7 : {1'b0, w};
            LAY_ALL_EXP: b = {1'b1, w};
            LAY_SPLIT:   b = (w == 2'd1) ? 3'd3 : ((w == 2'd3) ? 3'd7 : {1'b0, w});
            LAY_MID_X4,
            LAY_MID_X5,
            LAY_MID_X6,
            LAY_MID_X7:  b = (w == 2'd1) ? {1'b1, lay[1:0]} : {1'b0, w};
        endcase
        return b;
    endfunction

    for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
        assign win_blk[w] = pick(layout, WSEL_W'(w));
    end

endmodule

// File: rtl/phys_map.sv
module phys_map
    import bankmap_pkg::*;
#(
    parameter int BANK_COUNT = 8,
    parameter int OFF_W      = 14,
    localparam int PHYS_W    = BANK_W + 2 + OFF_W
)(
    input  logic [BANK_W-1:0] bank,
    input  logic [LBLK_W-1:0] blk,
    input  logic [OFF_W-1:0]  off,
    output logic [PHYS_W-1:0] phys
);

    logic [BANK_W-1:0] bank_eff;

    if (BANK_COUNT >= (1 << BANK_W)) begin : g_full
        assign bank_eff = bank;
    end else begin : g_wrap
        assign bank_eff = BANK_W'(int'(bank) % BANK_COUNT);
    end

    assign phys = blk[LBLK_W-1] ? {bank_eff, blk[1:0], off}
                                : {{BANK_W{1'b0}}, blk[1:0], off};

endmodule

// File: rtl/bank_window_map.sv
module bank_window_map
    import bankmap_pkg::*;
#(
    parameter int BANK_COUNT = 8,
    parameter int ADDR_W     = 16,
    localparam int OFF_W     = ADDR_W - WSEL_W,
    localparam int PHYS_W    = BANK_W + 2 + OFF_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_data,
    input  logic              rom_lo_en,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] vid_addr,
    output logic [PHYS_W-1:0] ram_addr,
    output logic              ram_rd,
    output logic              ram_wr,
    output logic              rom_sel,
    output logic [PHYS_W-1:0] vid_ram_addr
);

    bank_cmd_t                      cmd_q;
    logic [WIN_CNT-1:0][LBLK_W-1:0] win_blk;
    logic [WSEL_W-1:0]              win_sel;
    logic                           in_low_win;

    bank_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_data),
        .cmd_q   (cmd_q)
    );

    win_layout u_lay (
        .layout  (cmd_q.layout),
        .win_blk (win_blk)
    );

    assign win_sel = cpu_addr[ADDR_W-1 -: WSEL_W];

    phys_map #(.BANK_COUNT(BANK_COUNT), .OFF_W(OFF_W)) u_cpu_map (
        .bank (cmd_q.bank),
        .blk  (win_blk[win_sel]),
        .off  (cpu_addr[OFF_W-1:0]),
        .phys (ram_addr)
    );

    assign in_low_win   = (win_sel == '0);
    assign rom_sel      = cpu_rd && rom_lo_en && in_low_win;
    assign ram_rd       = cpu_rd && !rom_sel;
    assign ram_wr       = cpu_wr;
    assign vid_ram_addr = {{(PHYS_W-ADDR_W){1'b0}}, vid_addr};

    // R4: windows 0 and 2 keep their own low block bits in every layout
    p_even_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[ADDR_W-1] == cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2] == 1'b0) |->
            ram_addr[OFF_W+1:OFF_W] == cpu_addr[ADDR_W-1:ADDR_W-2]);

    // R6: a base-region physical block never carries bank bits from a low logical block
    p_base_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q.layout == LAY_FLAT) |-> ram_addr[PHYS_W-1 -: BANK_W] == '0);

    // R7: the physical bank never names an uninstalled bank
    p_bank_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ram_addr[PHYS_W-1 -: BANK_W]) < BANK_COUNT);

    // R8: register updates never move the video address
    p_vid_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(vid_addr) |-> $stable(vid_ram_addr));

    // R9: every read goes to exactly one source
    p_one_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |-> (rom_sel ^ ram_rd));

    // R10: a pure write reaches RAM and never the ROM
    p_write_ram_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd) |-> (ram_wr && !rom_sel));

    // R11: with the overlay off the ROM is never chosen
    p_rom_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_lo_en |-> !rom_sel);

endmodule

// File: tb/bank_window_map_tb_top.sv
module bank_window_map_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr;
    logic [7:0]  cfg_data;
    logic        rom_lo_en;
    logic [15:0] cpu_addr;
    logic        cpu_rd;
    logic        cpu_wr;
    logic [15:0] vid_addr;
    logic [18:0] ram_addr,  ram_addr3;
    logic        ram_rd,    ram_rd3;
    logic        ram_wr,    ram_wr3;
    logic        rom_sel,   rom_sel3;
    logic [18:0] vid_ram_addr, vid_ram_addr3;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [2:0] m_bank;
    logic [2:0] m_lay;

    always #5 clk = ~clk;

    bank_window_map dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .rom_lo_en(rom_lo_en), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .vid_addr(vid_addr), .ram_addr(ram_addr), .ram_rd(ram_rd), .ram_wr(ram_wr),
        .rom_sel(rom_sel), .vid_ram_addr(vid_ram_addr)
    );

    bank_window_map #(.BANK_COUNT(3)) dut3_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .rom_lo_en(rom_lo_en), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .vid_addr(vid_addr), .ram_addr(ram_addr3), .ram_rd(ram_rd3), .ram_wr(ram_wr3),
        .rom_sel(rom_sel3), .vid_ram_addr(vid_ram_addr3)
    );

    function automatic logic [2:0] ref_blk(input logic [2:0] lay, input logic [1:0] w);
        case (lay)
            3'd0: return {1'b0, w};
            3'd1: return (w == 2'd3) ? 3'd7 : {1'b0, w};
            3'd2: return {1'b1, w};
            3'd3: return (w == 2'd1) ? 3'd3 : ((w == 2'd3) ? 3'd7 : {1'b0, w});
            default: return (w == 2'd1) ? {1'b1, lay[1:0]} : {1'b0, w};
        endcase
    endfunction

    function automatic logic [18:0] ref_addr(input logic [2:0] bank, input logic [2:0] lay,
                                             input logic [15:0] a, input int nbanks);
        logic [2:0] b;
        logic [2:0] bk;
        b  = ref_blk(lay, a[15:14]);
        bk = 3'(int'(bank) % nbanks);
        if (b[2]) return {bk, b[1:0], a[13:0]};
        return {3'b000, b[1:0], a[13:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send_cmd(input logic [7:0] d);
        @(negedge clk);
        cfg_wr   = 1'b1;
        cfg_data = d;
        @(posedge clk);
        if (d[7:6] == 2'b11) begin
            m_bank = d[5:3];
            m_lay  = d[2:0];
        end
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic check_map(input string tag);
        logic [18:0] e8, e3;
        #1;
        e8 = ref_addr(m_bank, m_lay, cpu_addr, 8);
        e3 = ref_addr(m_bank, m_lay, cpu_addr, 3);
        check(ram_addr == e8, tag, 32'(ram_addr), 32'(e8));
        check(ram_addr3 == e3, "R7", 32'(ram_addr3), 32'(e3));
    endtask

    task automatic check_strobes();
        bit rs;
        #1;
        rs = cpu_rd && rom_lo_en && (cpu_addr[15:14] == 2'b00);
        check(rom_sel == rs, rom_lo_en ? "R9" : "R11", 32'(rom_sel), 32'(rs));
        check(ram_rd == (cpu_rd && !rs), rom_lo_en ? "R9" : "R11", 32'(ram_rd), 32'(cpu_rd && !rs));
        check(ram_wr == cpu_wr, "R10", 32'(ram_wr), 32'(cpu_wr));
        check(vid_ram_addr == {3'b000, vid_addr}, "R8", 32'(vid_ram_addr), 32'({3'b000, vid_addr}));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed      = 32'h5eed_1234;
        void'($urandom(seed));
        rst_n     = 1'b0;
        cfg_wr    = 1'b0;
        cfg_data  = 8'h00;
        rom_lo_en = 1'b0;
        cpu_addr  = 16'h0000;
        cpu_rd    = 1'b0;
        cpu_wr    = 1'b0;
        vid_addr  = 16'h0000;
        m_bank    = 3'd0;
        m_lay     = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state is the flat layout, bank 0
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            cpu_addr = {2'(w), 14'h2A5};
            #1;
            check(ram_addr == {3'b000, cpu_addr}, "R1", 32'(ram_addr), 32'({3'b000, cpu_addr}));
        end

        // R2 R4 R5 R6 R7: every tagged command against every window
        for (int v = 0; v < 64; v++) begin
            send_cmd(8'hC0 | 8'(v));
            for (int w = 0; w < 4; w++) begin
                @(negedge clk);
                cpu_addr = {2'(w), 14'($urandom)};
                check_map((v % 8) < 4 ? "R4" : "R5");
            end
        end

        // R2: new mapping visible right after the capture edge
        send_cmd(8'hD2);
        cpu_addr = 16'h4001;
        check_map("R2");
        check(ram_addr == {3'd2, 2'd1, 14'h0001}, "R6", 32'(ram_addr), 32'({3'd2, 2'd1, 14'h0001}));

        // R3: untagged writes leave the mapping alone
        for (int i = 0; i < 12; i++) begin
            send_cmd({2'(i % 3), 6'($urandom)});
            @(negedge clk);
            cpu_addr = 16'($urandom);
            check_map("R3");
        end

        // R8: video path ignores the layout-2 bank 7 setting
        send_cmd(8'hFA);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            vid_addr = 16'($urandom);
            check_strobes();
        end

        // R9 R10 R11: ROM overlay directed cases (bank 7, layout 2 active)
        @(negedge clk);
        rom_lo_en = 1'b1; cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_addr = 16'h1234;
        #1;
        check(rom_sel == 1'b1 && ram_rd == 1'b0, "R9", 32'({rom_sel, ram_rd}), 32'(2'b10));
        @(negedge clk);
        cpu_addr = 16'h4000;
        #1;
        check(rom_sel == 1'b0 && ram_rd == 1'b1, "R9", 32'({rom_sel, ram_rd}), 32'(2'b01));
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = 16'h3FFF;
        #1;
        check(ram_wr && !rom_sel, "R10", 32'({ram_wr, rom_sel}), 32'(2'b10));
        check(ram_addr == {3'd7, 2'd0, 14'h3FFF}, "R10", 32'(ram_addr), 32'({3'd7, 2'd0, 14'h3FFF}));
        @(negedge clk);
        rom_lo_en = 1'b0; cpu_rd = 1'b1; cpu_wr = 1'b0; cpu_addr = 16'h0000;
        #1;
        check(rom_sel == 1'b0 && ram_rd == 1'b1, "R11", 32'({rom_sel, ram_rd}), 32'(2'b01));

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 5) == 0) begin
                send_cmd(8'($urandom));
            end
            @(negedge clk);
            cpu_addr  = 16'($urandom);
            rom_lo_en = 1'($urandom);
            vid_addr  = 16'($urandom);
            case ($urandom % 3)
                0: begin cpu_rd = 1'b1; cpu_wr = 1'b0; end
                1: begin cpu_rd = 1'b0; cpu_wr = 1'b1; end
                default: begin cpu_rd = 1'b0; cpu_wr = 1'b0; end
            endcase
            check_map("R6");
            check_strobes();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule